// File: doc/BRIEF.md
# Dual-Mode Down-Counting Timer

This block is a down-counter that advances on one of two slow tick enables rather than on every system clock. Software writes a start value through a one-cycle write strobe. The value lands in the counter at once and is also kept as the reload value. The count is visible on an output bus at all times.

On every selected tick the counter steps down by one. The one exception is the first selected tick after a write, which is swallowed. This gives the written value one whole tick period before the first decrement.

When a tick arrives with the count already at zero, the counter underflows. In free-running mode it wraps to all ones and keeps counting down. In reload mode it restarts from the last written value, which makes the block a programmable periodic tick source. Every underflow latches an interrupt flag, which stays set until an explicit clear strobe. In reload mode a square-wave output also toggles on each underflow, which makes it suitable for driving a buzzer.

Top module: `slow_down_timer`

## Requirements
- R1: After reset the count output is 0, the interrupt output is 0 and the buzzer output is 0.
- R2: When `wr_en` is 1 at a clock edge, `count` equals `wr_data` after that edge, and the same value is kept as the reload value.
- R3: The first selected tick after a write leaves `count` unchanged. Every later selected tick on a nonzero count lowers it by exactly one.
- R4: `src_fast` = 1 makes `tick_fast` the counting tick and `src_fast` = 0 makes `tick_slow` the counting tick. Pulses on the unselected tick input leave `count` unchanged.
- R5: With `mode_reload` = 0 (free-running), a counting tick at count 0 sets `count` to 0xFFFF and sets `irq`.
- R6: With `mode_reload` = 1 (reload), a counting tick at count 0 sets `count` to the most recently written value and sets `irq`.
- R7: `irq` stays 1 until a cycle in which `irq_clr` is 1 and no underflow occurs. A write does not clear it. An underflow in the same cycle as `irq_clr` leaves it set.
- R8: In reload mode with a written value of 0, every counting tick after the swallowed first tick is an underflow: `count` stays 0 and `irq` is set again on each such tick.
- R9: `buzz` toggles on each underflow in reload mode and does not change at all in free-running mode.
- R10: A write in the same cycle as a selected tick takes priority. The count takes the written value, and the next selected tick is the swallowed first tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle strobe that loads the counter and the reload value |
| wr_data | input | 16 | Value to load |
| mode_reload | input | 1 | 0 = free-running wrap, 1 = reload on underflow |
| src_fast | input | 1 | 0 = count on `tick_slow` (512 Hz), 1 = count on `tick_fast` (2 kHz) |
| tick_slow | input | 1 | One-cycle enable at the slow rate |
| tick_fast | input | 1 | One-cycle enable at the fast rate |
| irq_clr | input | 1 | One-cycle strobe that clears the interrupt flag |
| count | output | 16 | Current counter value |
| irq | output | 1 | Latched underflow interrupt |
| buzz | output | 1 | Square wave toggled on each reload-mode underflow |

## Verification
The hardest situations to reach from the ports are the ones that need an internal arming state and a coincident event in the same cycle. Examples are an underflow that lands in the same cycle as `irq_clr`, and a write that lands in the same cycle as a selected tick. The stimulus first loads small values (3, 2 and 0), so that the count reaches zero within a few ticks. It then places the clear strobe or the write exactly on the underflow tick or on the arming tick. Pulses on the unselected tick input are interleaved throughout to show they have no effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        MODE_FREE   = 1'b0,
        MODE_RELOAD = 1'b1
    } tmr_mode_e;

    typedef struct packed {
        logic irq;
        logic buzz;
    } tmr_flag_t;

endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
    parameter int NSRC  = 2,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  ticks,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [NSRC-1:0] hit;

    // one-hot match of the selector against each source lane
    for (genvar i = 0; i < NSRC; i++) begin : g_lane
        assign hit[i] = ticks[i] & (sel == SEL_W'(i));
    end

    assign tick = |hit;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int WIDTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WIDTH-1:0]     wr_data,
    input  logic                 tick,
    input  tmr_pkg::tmr_mode_e   mode,
    output logic [WIDTH-1:0]     count,
    output logic                 armed,
    output logic                 underflow
);
    localparam logic [WIDTH-1:0] CNT_ONE = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic [WIDTH-1:0] rel;
        logic             armed;
    } core_t;

    core_t s_d, s_q;
    logic  uf_d;

    always_comb begin
        s_d  = s_q;
        uf_d = 1'b0;
        if (wr_en) begin
            s_d.cnt   = wr_data;
            s_d.rel   = wr_data;
            s_d.armed = 1'b0;
        end else if (tick) begin
            if (!s_q.armed) begin
                s_d.armed = 1'b1;
            end else if (s_q.cnt == '0) begin
                uf_d      = 1'b1;
                s_d.cnt   = (mode == tmr_pkg::MODE_RELOAD) ? s_q.rel : CNT_MAX;
            end else begin
                s_d.cnt   = s_q.cnt - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count     = s_q.cnt;
    assign armed     = s_q.armed;
    assign underflow = uf_d;
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               underflow,
    input  tmr_pkg::tmr_mode_e mode,
    input  logic               irq_clr,
    output logic               irq,
    output logic               buzz
);
    tmr_pkg::tmr_flag_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (underflow) begin
            f_d.irq = 1'b1;
        end else if (irq_clr) begin
            f_d.irq = 1'b0;
        end
        if (underflow && mode == tmr_pkg::MODE_RELOAD) begin
            f_d.buzz = ~f_q.buzz;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign irq  = f_q.irq;
    assign buzz = f_q.buzz;
endmodule

// File: rtl/slow_down_timer.sv
module slow_down_timer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             mode_reload,
    input  logic             src_fast,
    input  logic             tick_slow,
    input  logic             tick_fast,
    input  logic             irq_clr,
    output logic [WIDTH-1:0] count,
    output logic             irq,
    output logic             buzz
);
    localparam int NSRC = 2;

    tmr_pkg::tmr_mode_e mode;
    logic               sel_tick;
    logic               armed;
    logic               underflow;

    assign mode = tmr_pkg::tmr_mode_e'(mode_reload);

    tmr_tick_sel #(.NSRC(NSRC)) sel_i (
        .ticks ({tick_fast, tick_slow}),
        .sel   (src_fast),
        .tick  (sel_tick)
    );

    tmr_core #(.WIDTH(WIDTH)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tick      (sel_tick),
        .mode      (mode),
        .count     (count),
        .armed     (armed),
        .underflow (underflow)
    );

    tmr_flag flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .underflow (underflow),
        .mode      (mode),
        .irq_clr   (irq_clr),
        .irq       (irq),
        .buzz      (buzz)
    );
endmodule

// File: rtl/slow_down_timer_chk.sv
module slow_down_timer_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             mode_reload,
    input logic             src_fast,
    input logic             tick_slow,
    input logic             tick_fast,
    input logic             irq_clr,
    input logic [WIDTH-1:0] count,
    input logic             irq,
    input logic             buzz,
    input logic             armed
);
    logic             sel;
    logic             uf_ev;
    logic [WIDTH-1:0] shadow_q;

    assign sel   = src_fast ? tick_fast : tick_slow;
    assign uf_ev = !wr_en && sel && armed && (count == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_q <= '0;
        else if (wr_en) shadow_q <= wr_data;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> count == $past(wr_data));

    p_swallow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && sel && !armed) |=> ($stable(count) && armed));

    p_unsel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !sel) |=> $stable(count));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_ev && !mode_reload) |=> (count == '1 && irq));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_ev && mode_reload) |=> (count == $past(shadow_q) && irq));

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !uf_ev) |=> !irq);

    p_buzz_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(uf_ev && mode_reload) |=> $stable(buzz));

    p_buzz_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_ev && mode_reload) |=> (buzz != $past(buzz)));

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel) |=> !armed);
endmodule

bind slow_down_timer slow_down_timer_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .mode_reload (mode_reload),
    .src_fast    (src_fast),
    .tick_slow   (tick_slow),
    .tick_fast   (tick_fast),
    .irq_clr     (irq_clr),
    .count       (count),
    .irq         (irq),
    .buzz        (buzz),
    .armed       (armed)
);

// File: tb/slow_down_timer_tb_top.sv
module slow_down_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, mode_reload, src_fast, tick_slow, tick_fast, irq_clr;
    logic [15:0] wr_data;
    logic [15:0] count;
    logic        irq, buzz;

    always #4 clk = ~clk;

    slow_down_timer #(.WIDTH(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode_reload(mode_reload), .src_fast(src_fast),
        .tick_slow(tick_slow), .tick_fast(tick_fast), .irq_clr(irq_clr),
        .count(count), .irq(irq), .buzz(buzz)
    );

    typedef struct {
        logic [15:0] cnt;
        logic        irq;
        logic        buzz;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;

    // reference model state, built from the requirements
    logic [15:0] m_cnt = '0, m_rel = '0;
    logic        m_arm = 1'b0, m_irq = 1'b0, m_buzz = 1'b0;
    logic        cur_mode = 1'b0, cur_src = 1'b0;

    task automatic step(input logic w, input logic [15:0] d, input logic md,
                        input logic sf, input logic ts, input logic tf,
                        input logic clr, input string tag);
        exp_t e;
        logic sel, uf;
        @(negedge clk);
        wr_en = w; wr_data = d; mode_reload = md; src_fast = sf;
        tick_slow = ts; tick_fast = tf; irq_clr = clr;
        cur_mode = md; cur_src = sf;
        sel = sf ? tf : ts;
        uf  = 1'b0;
        if (w) begin
            m_cnt = d; m_rel = d; m_arm = 1'b0;
        end else if (sel) begin
            if (!m_arm) m_arm = 1'b1;
            else if (m_cnt == 16'h0000) begin
                uf = 1'b1;
                m_cnt = md ? m_rel : 16'hFFFF;
            end else m_cnt = m_cnt - 16'd1;
        end
        if (uf) m_irq = 1'b1;
        else if (clr) m_irq = 1'b0;
        if (uf && md) m_buzz = ~m_buzz;
        e.cnt = m_cnt; e.irq = m_irq; e.buzz = m_buzz; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic tick(input string tag);
        step(1'b0, 16'h0, cur_mode, cur_src, !cur_src, cur_src, 1'b0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++)
            step(1'b0, 16'h0, cur_mode, cur_src, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // monitor: compare each expected item two time units after the edge it belongs to
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (count !== e.cnt || irq !== e.irq || buzz !== e.buzz) begin
                fails++;
                $display("FAIL %s: count=%h irq=%b buzz=%b expected count=%h irq=%b buzz=%b",
                         e.tag, count, irq, buzz, e.cnt, e.irq, e.buzz);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; mode_reload = 1'b0;
        src_fast = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0; irq_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (count !== 16'h0 || irq !== 1'b0 || buzz !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: count=%h irq=%b buzz=%b expected 0000 0 0", count, irq, buzz);
        end

        // free-running mode on the slow source
        step(1'b1, 16'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 write load");
        tick("R3 first tick swallowed");
        step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 fast tick ignored on slow source");
        tick("R3 decrement");
        tick("R3 decrement");
        tick("R3 decrement to zero");
        tick("R5 wrap to FFFF with irq");
        tick("R5 continue after wrap");
        idle(2, "R7 irq held");
        step(1'b1, 16'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 write keeps irq");
        step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 clear strobe");
        tick("R9 buzz quiet in free mode");
        tick("R3 decrement");
        tick("R3 decrement to zero");
        step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R7 underflow beats clear");
        step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 clear");

        // reload mode on the fast source
        step(1'b1, 16'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 write load reload mode");
        step(1'b0, 16'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 slow tick ignored on fast source");
        tick("R3 first tick swallowed");
        tick("R3 decrement");
        tick("R3 decrement to zero");
        tick("R6 reload with irq and buzz toggle R9");
        tick("R6 decrement after reload");
        tick("R6 decrement");
        tick("R6 second reload R9 toggle");
        step(1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R7 clear");

        // reload value of zero
        step(1'b1, 16'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 write zero");
        tick("R8 first tick swallowed");
        tick("R8 underflow every tick");
        step(1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R7 clear between ticks");
        tick("R8 underflow every tick");
        tick("R8 underflow every tick");

        // write coincident with a selected tick
        step(1'b1, 16'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R10 write wins over tick");
        tick("R10 next tick swallowed");
        step(1'b1, 16'd9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10 write during armed state");
        tick("R10 re-arm swallow");
        tick("R10 decrement after rearm");
        idle(2, "R4 no tick hold");

        wait (q.size() == 0);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule